// File: doc/BRIEF.md
# Lane PHY Override Sequencer

This block walks one serial-link lane through the register script that re-applies PHY overrides after a link hard reset. It issues every access through a simple request/acknowledge register port: one request is outstanding at a time, and the block holds it stable until the acknowledge arrives. An override run has three phases. First it polls the receive status register until the half-rate flag drops, within a bounded retry budget. It then rewrites the receive override register, which drops the override, re-applies it, inserts the DPLL mode and pulses the DPLL reset. It waits a settling interval, then rewrites the transmit override register with an attenuation value unless the attenuation setting marks it as unused.

A second, shorter command only drops the receive override. Software or a reset controller uses it just before a hard reset. Both commands report through `busy` and a one-cycle `done` pulse. When a lane has no PHY attached, a command finishes at once without touching the register port.

Top module: `lane_ovr_seq`

## Requirements
- R1: After reset, and after a reset applied in the middle of a run, `busy`, `done` and `req_valid` are low.
- R2: Every access goes to a register offset plus lane × 0x100. The offsets are: receive status 0x2002, transmit status 0x2001, receive override 0x2005 and transmit override 0x2004.
- R3: An override run first reads receive status and repeats that read while bit 0 (half-rate) is set, with at most POLL_MAX repeats. The bench uses a POLL_MAX of 1000.
- R4: After polling, one more read of receive status gives a working word. Five writes to receive override follow: the word with bit 14 cleared, then bit 14 set, then bits 10:8 replaced by 3, then bit 11 set, then bit 11 cleared.
- R5: After the last receive-override write is acknowledged, no request is made for at least SETTLE_CYC cycles.
- R6: The transmit phase reads transmit status. It then writes to transmit override the word with bit 15 cleared, then with bit 15 set, then with attenuation bits 2:0 ORed into bits 12:10.
- R7: If attenuation bit 3 is set, the transmit phase is skipped. `done` follows the settling wait with no further access.
- R8: The disable command reads receive status and writes it to receive override with bit 14 cleared. It makes no other access.
- R9: With `phy_present` low at the start, a command raises `done` in the cycle after it is accepted and makes no access.
- R10: A request holds its address, direction and data until acknowledged. `busy` is high from the cycle after a start until `done`. `done` lasts one cycle, with `busy` low. When both starts arrive together, the override run is taken.
- R11: Start commands that arrive while a run is busy are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_override | input | 1 | Start the post-reset override run |
| start_disable | input | 1 | Start the receive-override drop |
| phy_present | input | 1 | Lane has a PHY; sampled with a start |
| lane | input | LANE_W | Lane number; sampled with a start |
| atten | input | 4 | Attenuation setting; bit 3 set skips the transmit phase |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle completion pulse |
| req_valid | output | 1 | Register access request |
| req_write | output | 1 | 1 = write, 0 = read |
| req_addr | output | 16 | Register address |
| req_wdata | output | 16 | Write data |
| req_ack | input | 1 | Access complete; read data valid |
| rsp_rdata | input | 16 | Read data |

## Verification
Each vector is compared as a complete access trace against a list that the bench builds from the requirements, so wrong addresses, wrong bit edits and wrong write orders all show up. The status words are chosen with the override, mode and reset bits set differently, so that a missing clear or set changes the data. The poll count is tried at zero, a few, exactly the retry budget, and over the budget: the last case carries a half-rate flag into the working word. Attenuation values with bit 3 set, lanes without a PHY, colliding starts and a reset in mid-run separate the skip, bypass and ignore paths from the main run.

// File: rtl/lane_ovr_pkg.sv
// Shared constants and types for the lane override sequencer.
// Assumes 16-bit register addresses and data on the access port.
package lane_ovr_pkg;
    localparam int ADDR_W     = 16;
    localparam int DATA_W     = 16;
    localparam int LANE_SHIFT = 8;

    localparam logic [ADDR_W-1:0] OFS_TX_STS = 16'h2001;
    localparam logic [ADDR_W-1:0] OFS_RX_STS = 16'h2002;
    localparam logic [ADDR_W-1:0] OFS_TX_OVR = 16'h2004;
    localparam logic [ADDR_W-1:0] OFS_RX_OVR = 16'h2005;

    localparam int HALF_BIT   = 0;
    localparam int RX_OVR_BIT = 14;
    localparam int TX_OVR_BIT = 15;
    localparam int RST_BIT    = 11;
    localparam int MODE_LSB   = 8;
    localparam int MODE_W     = 3;
    localparam int ATT_LSB    = 10;
    localparam int ATT_W      = 3;
    localparam logic [MODE_W-1:0] RX_MODE = 3'd3;

    typedef enum logic [4:0] {
        S_IDLE, S_POLL, S_RXRD, S_RXW0, S_RXW1, S_RXW2, S_RXW3, S_RXW4,
        S_SETTLE, S_TXRD, S_TXW0, S_TXW1, S_TXW2, S_DISRD, S_DISWR, S_DONE
    } seq_state_t;

    typedef enum logic [2:0] {
        E_CLR_RXOV, E_SET_RXOV, E_MODE, E_SET_RST,
        E_CLR_RST, E_CLR_TXOV, E_SET_TXOV, E_ATTEN
    } edit_op_t;
endpackage

// File: rtl/lane_ovr_edit.sv
// Word editor: applies one read-modify-write step to the working word.
// Purely combinational; the caller holds the working word.
module lane_ovr_edit
    import lane_ovr_pkg::*;
(
    input  edit_op_t          op,
    input  logic [DATA_W-1:0] cur,
    input  logic [ATT_W-1:0]  att,
    output logic [DATA_W-1:0] nxt
);
    // Build the next word from the current one for the selected step.
    always_comb begin
        nxt = cur;
        case (op)
            E_CLR_RXOV: nxt[RX_OVR_BIT] = 1'b0;
            E_SET_RXOV: nxt[RX_OVR_BIT] = 1'b1;
            E_MODE:     nxt[MODE_LSB +: MODE_W] = RX_MODE;
            E_SET_RST:  nxt[RST_BIT] = 1'b1;
            E_CLR_RST:  nxt[RST_BIT] = 1'b0;
            E_CLR_TXOV: nxt[TX_OVR_BIT] = 1'b0;
            E_SET_TXOV: nxt[TX_OVR_BIT] = 1'b1;
            E_ATTEN:    nxt[ATT_LSB +: ATT_W] = cur[ATT_LSB +: ATT_W] | att;
            default:    nxt = cur;
        endcase
    end
endmodule

// File: rtl/lane_ovr_cnt.sv
// Loadable down-counter that stops at zero. It is used for the poll
// budget and the settling wait. Assumes MAXV >= 1.
module lane_ovr_cnt #(
    parameter int unsigned MAXV = 1000,
    localparam int CW = $clog2(MAXV + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          dec,
    output logic [CW-1:0] cnt,
    output logic          zero
);
    // Load the limit, or step down toward zero.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt <= '0;
        else if (load)         cnt <= CW'(MAXV);
        else if (dec && !zero) cnt <= cnt - 1'b1;
    end

    // Flag the exhausted count.
    always_comb zero = (cnt == '0);
endmodule

// File: rtl/lane_ovr_seq.sv
// Lane PHY override sequencer. It runs a fixed register script through a
// request/acknowledge port: one access outstanding, held until req_ack.
// lane, atten and phy_present are sampled only when a start is accepted.
module lane_ovr_seq
    import lane_ovr_pkg::*;
#(
    parameter int          LANE_W     = 2,
    parameter int          ATTEN_W    = 4,
    parameter int unsigned POLL_MAX   = 1000,
    parameter int unsigned SETTLE_CYC = 1500000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_override,
    input  logic              start_disable,
    input  logic              phy_present,
    input  logic [LANE_W-1:0] lane,
    input  logic [ATTEN_W-1:0] atten,
    output logic              busy,
    output logic              done,
    output logic              req_valid,
    output logic              req_write,
    output logic [ADDR_W-1:0] req_addr,
    output logic [DATA_W-1:0] req_wdata,
    input  logic              req_ack,
    input  logic [DATA_W-1:0] rsp_rdata
);
    localparam int SKIP_BIT = ATTEN_W - 1;
    localparam int PCW      = $clog2(POLL_MAX + 1);
    localparam int SCW      = $clog2(SETTLE_CYC + 1);

    seq_state_t         state;
    logic [LANE_W-1:0]  lane_q;
    logic [ATTEN_W-1:0] atten_q;
    logic [DATA_W-1:0]  work_q;
    logic [ADDR_W-1:0]  ofs;
    edit_op_t           op;
    logic [PCW-1:0]     poll_cnt;
    logic [SCW-1:0]     settle_cnt;
    logic               poll_zero, settle_zero;
    logic               poll_load, poll_dec, settle_load, settle_dec;
    logic               accept;

    // Poll budget and settling timer.
    lane_ovr_cnt #(.MAXV(POLL_MAX)) u_poll (
        .clk(clk), .rst_n(rst_n), .load(poll_load), .dec(poll_dec),
        .cnt(poll_cnt), .zero(poll_zero)
    );
    lane_ovr_cnt #(.MAXV(SETTLE_CYC)) u_settle (
        .clk(clk), .rst_n(rst_n), .load(settle_load), .dec(settle_dec),
        .cnt(settle_cnt), .zero(settle_zero)
    );

    // Step editor for the write data.
    lane_ovr_edit u_edit (
        .op(op), .cur(work_q), .att(atten_q[ATT_W-1:0]), .nxt(req_wdata)
    );

    // Counter controls.
    always_comb begin
        poll_load   = (state == S_IDLE) && start_override;
        poll_dec    = (state == S_POLL) && req_ack && rsp_rdata[HALF_BIT];
        settle_load = (state == S_RXW4) && req_ack;
        settle_dec  = (state == S_SETTLE);
        accept      = (state == S_IDLE) && (start_override || start_disable);
    end

    // Decode the access kind, target register and edit step from the state.
    always_comb begin
        req_valid = 1'b1;
        req_write = 1'b1;
        ofs       = OFS_RX_OVR;
        op        = E_CLR_RXOV;
        case (state)
            S_POLL, S_RXRD, S_DISRD: begin req_write = 1'b0; ofs = OFS_RX_STS; end
            S_TXRD:  begin req_write = 1'b0; ofs = OFS_TX_STS; end
            S_RXW0, S_DISWR: op = E_CLR_RXOV;
            S_RXW1:  op = E_SET_RXOV;
            S_RXW2:  op = E_MODE;
            S_RXW3:  op = E_SET_RST;
            S_RXW4:  op = E_CLR_RST;
            S_TXW0:  begin ofs = OFS_TX_OVR; op = E_CLR_TXOV; end
            S_TXW1:  begin ofs = OFS_TX_OVR; op = E_SET_TXOV; end
            S_TXW2:  begin ofs = OFS_TX_OVR; op = E_ATTEN; end
            default: begin req_valid = 1'b0; req_write = 1'b0; end
        endcase
        req_addr = ofs + (ADDR_W'(lane_q) << LANE_SHIFT);
    end

    // Status outputs.
    always_comb begin
        done = (state == S_DONE);
        busy = (state != S_IDLE) && (state != S_DONE);
    end

    // Sequencer: advance on acknowledge, keep the working word up to date.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            lane_q  <= '0;
            atten_q <= '0;
            work_q  <= '0;
        end else begin
            if (accept) begin
                lane_q  <= lane;
                atten_q <= atten;
            end
            if (req_ack && req_valid)
                work_q <= req_write ? req_wdata : rsp_rdata;
            case (state)
                S_IDLE: begin
                    if (start_override)     state <= phy_present ? S_POLL  : S_DONE;
                    else if (start_disable) state <= phy_present ? S_DISRD : S_DONE;
                end
                S_POLL:   if (req_ack && !(rsp_rdata[HALF_BIT] && !poll_zero)) state <= S_RXRD;
                S_RXRD:   if (req_ack) state <= S_RXW0;
                S_RXW0:   if (req_ack) state <= S_RXW1;
                S_RXW1:   if (req_ack) state <= S_RXW2;
                S_RXW2:   if (req_ack) state <= S_RXW3;
                S_RXW3:   if (req_ack) state <= S_RXW4;
                S_RXW4:   if (req_ack) state <= S_SETTLE;
                S_SETTLE: if (settle_zero) state <= atten_q[SKIP_BIT] ? S_DONE : S_TXRD;
                S_TXRD:   if (req_ack) state <= S_TXW0;
                S_TXW0:   if (req_ack) state <= S_TXW1;
                S_TXW1:   if (req_ack) state <= S_TXW2;
                S_TXW2:   if (req_ack) state <= S_DONE;
                S_DISRD:  if (req_ack) state <= S_DISWR;
                S_DISWR:  if (req_ack) state <= S_DONE;
                default:  state <= S_IDLE;
            endcase
        end
    end

    // R10: a pending request stays put until it is acknowledged.
    a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ack |=> req_valid && $stable(req_addr)
                                  && $stable(req_write) && $stable(req_wdata));
    // R10: completion is a single-cycle pulse.
    a_r10_done_once: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R2, R11: the lane field of back-to-back requests within a run never moves.
    a_r11_lane_held: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && $past(req_valid) && $past(busy)
        |-> req_addr[LANE_SHIFT +: LANE_W] == $past(req_addr[LANE_SHIFT +: LANE_W]));
    // R4: the mode write carries the forced DPLL mode.
    a_r4_mode_write: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && state == S_RXW2 |-> req_write && req_wdata[MODE_LSB +: MODE_W] == RX_MODE);
    // R6: the attenuation write keeps the transmit override set.
    a_r6_atten_write: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && state == S_TXW2 |-> req_wdata[TX_OVR_BIT]);
    // R7: the transmit phase is never entered with the skip bit set.
    a_r7_skip: assert property (@(posedge clk) disable iff (!rst_n)
        state == S_TXRD |-> !atten_q[SKIP_BIT]);
    // R3: the poll budget counter never exceeds its limit.
    a_r3_poll_bound: assert property (@(posedge clk) disable iff (!rst_n)
        poll_cnt <= PCW'(POLL_MAX));
endmodule

// File: tb/test_lane_ovr_seq.sv
// Bench: register-port model, expected traces built from the requirements.
module test_lane_ovr_seq;
    import lane_ovr_pkg::*;

    localparam int SETTLE = 20;
    localparam int POLL   = 1000;
    localparam int LOGN   = 1100;
    localparam int NV     = 8;

    typedef struct packed {
        logic        dis;
        logic [1:0]  ln;
        logic [3:0]  att;
        logic        pres;
        logic [15:0] rx;
        logic [15:0] tx;
        logic [11:0] half;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{1'b0, 2'd0, 4'd5, 1'b1, 16'h4a51, 16'h8003, 12'd0},
        '{1'b0, 2'd3, 4'd2, 1'b1, 16'h0700, 16'h0000, 12'd3},
        '{1'b0, 2'd1, 4'd9, 1'b1, 16'hffff, 16'h1234, 12'd1},
        '{1'b1, 2'd2, 4'd0, 1'b1, 16'h4321, 16'h0000, 12'd0},
        '{1'b0, 2'd2, 4'd7, 1'b0, 16'h1111, 16'h2222, 12'd0},
        '{1'b1, 2'd1, 4'd0, 1'b0, 16'h1111, 16'h2222, 12'd0},
        '{1'b0, 2'd1, 4'd0, 1'b1, 16'hc8f0, 16'h7c00, 12'd1000},
        '{1'b0, 2'd0, 4'd3, 1'b1, 16'h0a0a, 16'h0001, 12'd1005}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic start_override = 1'b0, start_disable = 1'b0, phy_present = 1'b0;
    logic [1:0] lane = '0;
    logic [3:0] atten = '0;
    logic busy, done, req_valid, req_write, req_ack = 1'b0;
    logic [15:0] req_addr, req_wdata, rsp_rdata = '0;

    always #5 clk = ~clk;

    lane_ovr_seq #(.LANE_W(2), .POLL_MAX(POLL), .SETTLE_CYC(SETTLE)) i_lane_ovr_seq (
        .clk(clk), .rst_n(rst_n), .start_override(start_override),
        .start_disable(start_disable), .phy_present(phy_present), .lane(lane),
        .atten(atten), .busy(busy), .done(done), .req_valid(req_valid),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_ack(req_ack), .rsp_rdata(rsp_rdata)
    );

    int nchk = 0, nfail = 0, cyc = 0;
    int nlog = 0, nexp = 0, rx_reads = 0, settle_idx = -1, done_cyc = 0;
    logic        lg_w [LOGN];
    logic [15:0] lg_a [LOGN], lg_d [LOGN];
    int          lg_c [LOGN];
    logic        ex_w [LOGN];
    logic [15:0] ex_a [LOGN], ex_d [LOGN];
    string       ex_t [LOGN];
    logic [1:0]  m_lane = '0;
    logic [15:0] m_rx = '0, m_tx = '0;
    int          m_half = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // Register-port model: acknowledges every other negedge, logs accesses.
    always @(negedge clk) begin
        logic [15:0] rv;
        if (req_ack) req_ack = 1'b0;
        else if (req_valid) begin
            rv = 16'hbad0;
            if (req_addr == OFS_RX_STS + (16'(m_lane) << 8)) begin
                rv = {m_rx[15:1], rx_reads < m_half};
                rx_reads++;
            end else if (req_addr == OFS_TX_STS + (16'(m_lane) << 8)) rv = m_tx;
            rsp_rdata = rv;
            req_ack = 1'b1;
            if (nlog < LOGN) begin
                lg_w[nlog] = req_write;
                lg_a[nlog] = req_addr;
                lg_d[nlog] = req_write ? req_wdata : rv;
                lg_c[nlog] = cyc;
                nlog++;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic push(input bit w, input logic [15:0] a, input logic [15:0] d, input string t);
        ex_w[nexp] = w; ex_a[nexp] = a; ex_d[nexp] = d; ex_t[nexp] = t;
        nexp++;
    endtask

    // Expected trace, written from the requirements.
    task automatic build_exp(input vec_t v);
        logic [15:0] lo, t;
        int k;
        nexp = 0; settle_idx = -1;
        lo = 16'(v.ln) * 16'h100;
        if (!v.pres) return;
        if (v.dis) begin
            t = {v.rx[15:1], 1'b0 < 1'(v.half != 0)};
            push(0, 16'h2002 + lo, t, "R8");
            push(1, 16'h2005 + lo, t & ~16'h4000, "R8");
            return;
        end
        k = 0;
        for (int j = 0; j <= POLL; j++) begin
            push(0, 16'h2002 + lo, {v.rx[15:1], k < int'(v.half)}, "R3");
            k++;
            if (!(k - 1 < int'(v.half))) break;
        end
        t = {v.rx[15:1], k < int'(v.half)};
        push(0, 16'h2002 + lo, t, "R4");
        t = t & ~16'h4000;                    push(1, 16'h2005 + lo, t, "R4");
        t = t | 16'h4000;                     push(1, 16'h2005 + lo, t, "R4");
        t = (t & ~16'h0700) | 16'h0300;       push(1, 16'h2005 + lo, t, "R4");
        t = t | 16'h0800;                     push(1, 16'h2005 + lo, t, "R4");
        t = t & ~16'h0800;                    push(1, 16'h2005 + lo, t, "R4");
        settle_idx = nexp - 1;
        if (v.att[3]) return;
        t = v.tx;
        push(0, 16'h2001 + lo, t, "R6");
        t = t & ~16'h8000;                    push(1, 16'h2004 + lo, t, "R6");
        t = t | 16'h8000;                     push(1, 16'h2004 + lo, t, "R6");
        t = t | ((16'(v.att) & 16'h7) << 10); push(1, 16'h2004 + lo, t, "R6");
    endtask

    // One command: start, optional colliding starts, wait, compare trace.
    task automatic run_case(input vec_t v, input int poke, input bit both);
        int k;
        build_exp(v);
        m_lane = v.ln; m_rx = v.rx; m_tx = v.tx; m_half = int'(v.half);
        rx_reads = 0; nlog = 0;
        @(negedge clk);
        start_override = !v.dis; start_disable = v.dis | both;
        lane = v.ln; atten = v.att; phy_present = v.pres;
        @(negedge clk);
        start_override = 1'b0; start_disable = 1'b0;
        if (!v.pres) chk(done == 1'b1, "R9", "done after start without PHY", 32'(done), 1);
        else         chk(busy == 1'b1, "R10", "busy after start", 32'(busy), 1);
        k = 0;
        while (!done && k < 20000) begin
            @(negedge clk);
            k++;
            if (poke > 0 && k == poke) begin
                start_override = 1'b1; start_disable = 1'b1; lane = 2'd3; atten = 4'd8;
            end else if (poke > 0 && k == poke + 1) begin
                start_override = 1'b0; start_disable = 1'b0;
            end
        end
        done_cyc = cyc;
        chk(done == 1'b1, "R10", "done reached", 32'(done), 1);
        chk(busy == 1'b0, "R10", "busy low with done", 32'(busy), 0);
        chk(nlog == nexp, v.pres ? "R2" : "R9", "access count", 32'(nlog), 32'(nexp));
        for (int i = 0; i < nexp && i < nlog; i++) begin
            chk(lg_w[i] == ex_w[i] && lg_a[i] == ex_a[i], "R2", $sformatf("access %0d addr/dir", i),
                {15'd0, lg_w[i], lg_a[i]}, {15'd0, ex_w[i], ex_a[i]});
            chk(lg_d[i] == ex_d[i], ex_t[i], $sformatf("access %0d data", i),
                32'(lg_d[i]), 32'(ex_d[i]));
        end
        if (settle_idx >= 0 && settle_idx < nlog) begin
            if (settle_idx + 1 < nlog)
                chk(lg_c[settle_idx + 1] - lg_c[settle_idx] >= SETTLE + 1 &&
                    lg_c[settle_idx + 1] - lg_c[settle_idx] <= SETTLE + 3, "R5",
                    "settle gap", 32'(lg_c[settle_idx + 1] - lg_c[settle_idx]), SETTLE + 2);
            else
                chk(done_cyc - lg_c[settle_idx] >= SETTLE, "R7", "settle before skip-done",
                    32'(done_cyc - lg_c[settle_idx]), SETTLE + 2);
        end
        @(negedge clk);
        chk(done == 1'b0, "R10", "done pulse length", 32'(done), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL R10 watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy && !done && !req_valid, "R1", "outputs in reset",
            {29'd0, busy, done, req_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !req_valid, "R1", "outputs after reset",
            {29'd0, busy, done, req_valid}, 0);

        for (int n = 0; n < NV; n++) run_case(VECS[n], 0, 1'b0);

        // R11: starts arriving mid-run leave the running trace untouched.
        run_case('{1'b0, 2'd1, 4'd2, 1'b1, 16'h1111, 16'h2222, 12'd0}, 3, 1'b0);
        // R10: both starts at once take the override run.
        run_case('{1'b0, 2'd2, 4'd1, 1'b1, 16'h5a5a, 16'ha5a5, 12'd2}, 0, 1'b1);

        // R1: reset in the middle of a run returns to idle.
        @(negedge clk);
        start_override = 1'b1; lane = 2'd0; atten = 4'd0; phy_present = 1'b1;
        m_half = 50; rx_reads = 0; m_lane = 2'd0;
        @(negedge clk);
        start_override = 1'b0;
        repeat (6) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(!busy && !done && !req_valid, "R1", "outputs after mid-run reset",
            {29'd0, busy, done, req_valid}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!busy && !req_valid, "R1", "idle after mid-run reset release",
            {30'd0, busy, req_valid}, 0);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule